// File: doc/BRIEF.md
# Multi-Slot Inter-Processor Mailbox Controller

This block carries short messages from one sending core to a set of up to eight remote receivers through a single 32-bit register port. The sender fills a header word and a 64-bit short payload, then starts one of four independent message slots. The header carries a bitmap of the receivers it is meant for. On the start write, the slot takes a private copy of the header and payload. Every addressed receiver then shows a pending bit in the shared receive status word. Each receiver reads the latched message through its own window of the register space and acknowledges that slot on its own.

A slot stays busy until every addressed receiver has acknowledged it, or until the sender cancels it. While it is busy, its send bit reads back as one, so software can poll that bit to learn when the message has completed. When a message is delivered, a latched interrupt status bit is set for each addressed receiver and slot. These bits are masked by an enable register and cleared by writing ones. A small bank of identifier registers reports whether every identifier byte has been programmed to a non-zero value.

Top module: `mbx_ctrl`

## Requirements
- R1: After a synchronous reset: the status word (0x01C), every slot control word (0x00C + 4·slot), the interrupt status (0x3F8), irq_o, wake_o and ids_ok_o all read zero.
- R2: A write of bit 0 (send) to an idle slot's control word does the following. It sets status bit receiver·4+slot for each receiver whose bit is set in header bits 23:16. The header is the word written at 0x000. The slot's send bit then reads 1. If the destination bitmap is zero, no status bit is set and the send bit stays 0.
- R3: A receiver reads a slot's message at 0x02C + receiver·0x30 + slot·0xC. That offset holds the header, +4 holds the payload low word and +8 holds the payload high word. These values are the ones held in 0x000, 0x004 and 0x008 at the start write. Later writes to those three registers do not change them.
- R4: Writing 1 to bit receiver·4+slot of the acknowledge register (0x024) clears only that status bit. The slot's send bit stays 1 while any other addressed receiver is still pending.
- R5: The slot's send bit reads 0 once the last addressed receiver of that slot has acknowledged.
- R6: A send written to a slot whose send bit is set is ignored. The latched message and the status bits stay unchanged.
- R7: Writing bit 8 (cancel) to a slot's control word does three things in one cycle: it clears all of that slot's status bits, it clears its send bit, and it leaves the cancel bit reading 0. A write that sets both cancel and send acts as a cancel.
- R8: Every write to a slot's control word stores bit 16 (wake). The stored bit reads back in bit 16 of that control word and drives wake_o[slot].
- R9: A delivery sets interrupt status bit receiver·4+slot, which reads at 0x3F8. Writing 1s to 0x3F4 clears those bits. irq_o is the OR of (interrupt status AND the enable register at 0x3F0) and takes one more cycle to follow them.
- R10: The identifier registers at 0x200 + 4·i (i < 5) read back what was written. ids_ok_o is 1 only when all four bytes of every identifier register are non-zero.
- R11: reg_rdata holds the addressed register one cycle after reg_rd. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| irq_o | output | 1 | Interrupt: enabled latched status present |
| wake_o | output | 4 | Stored wake bit of each slot |
| ids_ok_o | output | 1 | Every identifier byte is non-zero |

## Verification
Directed sequences walk one slot through its life: a two-receiver send, partial and final acknowledges, a send while busy, a cancel, a send with an empty destination bitmap, and a write that sets both cancel and send. Between them they show whether completion waits for the last receiver, and whether a busy slot or a cancel leaves stale state behind. The interrupt is checked with the enable off, then on, then cleared, which tells the latched status apart from the live pending bits. Seeded random rounds mix sends with random bitmaps, random multi-bit acknowledges, cancels and enable/clear writes across all slots. The status word, the control words, the receiver windows and irq_o are compared against a bench model, which shows up any cross-talk between slots or receivers.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_TX_HDR = 12'h000;
  localparam logic [ADDR_W-1:0] A_TX_LO  = 12'h004;
  localparam logic [ADDR_W-1:0] A_TX_HI  = 12'h008;
  localparam logic [ADDR_W-1:0] A_CTL0   = 12'h00C;
  localparam logic [ADDR_W-1:0] A_STAT   = 12'h01C;
  localparam logic [ADDR_W-1:0] A_ACK    = 12'h024;
  localparam logic [ADDR_W-1:0] A_RXWIN  = 12'h02C;
  localparam logic [ADDR_W-1:0] A_ID0    = 12'h200;
  localparam logic [ADDR_W-1:0] A_IEN    = 12'h3F0;
  localparam logic [ADDR_W-1:0] A_ICLR   = 12'h3F4;
  localparam logic [ADDR_W-1:0] A_ISTAT  = 12'h3F8;

  localparam int SLOT_STRIDE = 12;

  localparam int CTL_SEND   = 0;
  localparam int CTL_CANCEL = 8;
  localparam int CTL_WAKE   = 16;
  localparam int HDR_DEST_LSB = 16;
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int NUM_RX = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              send_bit,
  input  logic              cancel_bit,
  input  logic              wake_bit,
  input  logic [31:0]       hdr_in,
  input  logic [63:0]       pay_in,
  input  logic              ack_wr,
  input  logic [NUM_RX-1:0] ack_bits,
  output logic [NUM_RX-1:0] pend_o,
  output logic              busy_o,
  output logic              wake_o,
  output logic [31:0]       hdr_o,
  output logic [63:0]       pay_o,
  output logic [NUM_RX-1:0] dlv_o
);
  import mbx_pkg::*;

  logic [NUM_RX-1:0] pend_q, pend_d, dest;
  logic              busy_q, busy_d;
  logic              send_ok, cancel;

  assign dest    = hdr_in[HDR_DEST_LSB +: NUM_RX];
  assign cancel  = ctl_wr && cancel_bit;
  assign send_ok = ctl_wr && send_bit && !cancel_bit && !busy_q;
  assign dlv_o   = send_ok ? dest : '0;

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    if (cancel) begin
      pend_d = '0;
      busy_d = 1'b0;
    end else if (send_ok) begin
      pend_d = dest;
      busy_d = |dest;
    end else if (ack_wr) begin
      pend_d = pend_q & ~ack_bits;
      busy_d = busy_q && (|pend_d);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      busy_q <= 1'b0;
      wake_o <= 1'b0;
      hdr_o  <= '0;
      pay_o  <= '0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      if (ctl_wr) wake_o <= wake_bit;
      if (send_ok) begin
        hdr_o <= hdr_in;
        pay_o <= pay_in;
      end
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;

  // R5: slot is busy exactly while some addressed receiver is pending
  p_busy_tracks_pend_r5: assert property (@(posedge clk) disable iff (rst)
    busy_q == (|pend_q));

  // R6: a send into a busy slot leaves message and pending bits alone
  p_busy_send_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && send_bit && !cancel_bit && busy_q && !ack_wr)
      |=> ($stable(hdr_o) && $stable(pay_o) && $stable(pend_q)));

  // R7: cancel empties the slot in one cycle
  p_cancel_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && cancel_bit) |=> (!busy_q && pend_q == '0));

  // R4: an acknowledge never raises a pending bit
  p_ack_never_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && !ctl_wr) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         en_wr,
  input  logic         clr_wr,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);
  logic [W-1:0] clr_mask;
  assign clr_mask = clr_wr ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= '0;
      stat_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (en_wr) en_o <= wdata_i;
      stat_o <= (stat_o & ~clr_mask) | set_i;
      irq_o  <= |(stat_o & en_o);
    end
  end

  // R9: a delivery is latched even when a clear lands in the same cycle
  p_set_latches_r9: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i)));

  // R9: with nothing enabled the line stays low
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(en_o) == '0) |-> !irq_o);
endmodule

// File: rtl/mbx_ids.sv
module mbx_ids #(
  parameter int NUM_ID = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_ID-1:0] wr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       ids_o [NUM_ID],
  output logic              ok_o
);
  logic all_set;

  always_comb begin
    all_set = 1'b1;
    for (int i = 0; i < NUM_ID; i++)
      for (int b = 0; b < 4; b++)
        if (ids_o[i][8*b +: 8] == 8'h00) all_set = 1'b0;
  end

  for (genvar i = 0; i < NUM_ID; i++) begin : g_id
    always_ff @(posedge clk) begin
      if (rst) ids_o[i] <= '0;
      else if (wr_i[i]) ids_o[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ok_o <= 1'b0;
    else     ok_o <= all_set;
  end

  // R10: a zero byte in the first identifier keeps the flag low
  p_zero_id_blocks_ok_r10: assert property (@(posedge clk) disable iff (rst)
    (ids_o[0][7:0] == 8'h00) |=> !ok_o);
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int NUM_RX   = 8,
  parameter int NUM_SLOT = 4,
  parameter int NUM_ID   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_o,
  output logic [NUM_SLOT-1:0] wake_o,
  output logic                ids_ok_o
);
  localparam int ST_W    = NUM_RX * NUM_SLOT;
  localparam int PSTRIDE = NUM_SLOT * SLOT_STRIDE;
  localparam logic [ADDR_W-1:0] RXWIN_END = A_RXWIN + ADDR_W'(NUM_RX * PSTRIDE);

  logic [31:0] tx_hdr_q, tx_lo_q, tx_hi_q;

  logic [NUM_SLOT-1:0] ctl_wr, busy_w;
  logic [NUM_RX-1:0]   pend_w [NUM_SLOT];
  logic [NUM_RX-1:0]   dlv_w  [NUM_SLOT];
  logic [NUM_RX-1:0]   ack_w  [NUM_SLOT];
  logic [31:0]         hdr_w  [NUM_SLOT];
  logic [63:0]         pay_w  [NUM_SLOT];
  logic [ST_W-1:0]     stat_w, set_w, ien_w, ist_w;
  logic                ack_wr;
  logic [NUM_ID-1:0]   id_wr;
  logic [31:0]         ids_w [NUM_ID];

  assign ack_wr = reg_wr && (reg_addr == A_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hdr_q <= '0;
      tx_lo_q  <= '0;
      tx_hi_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_TX_HDR) tx_hdr_q <= reg_wdata;
      if (reg_addr == A_TX_LO)  tx_lo_q  <= reg_wdata;
      if (reg_addr == A_TX_HI)  tx_hi_q  <= reg_wdata;
    end
  end

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    assign ctl_wr[s] = reg_wr && (reg_addr == A_CTL0 + ADDR_W'(4 * s));
    for (genvar p = 0; p < NUM_RX; p++) begin : g_rx
      assign ack_w[s][p]             = reg_wdata[p*NUM_SLOT + s];
      assign stat_w[p*NUM_SLOT + s]  = pend_w[s][p];
      assign set_w[p*NUM_SLOT + s]   = dlv_w[s][p];
    end
    mbx_slot #(.NUM_RX(NUM_RX)) u_slot (
      .clk(clk), .rst(rst),
      .ctl_wr(ctl_wr[s]),
      .send_bit(reg_wdata[CTL_SEND]),
      .cancel_bit(reg_wdata[CTL_CANCEL]),
      .wake_bit(reg_wdata[CTL_WAKE]),
      .hdr_in(tx_hdr_q),
      .pay_in({tx_hi_q, tx_lo_q}),
      .ack_wr(ack_wr),
      .ack_bits(ack_w[s]),
      .pend_o(pend_w[s]),
      .busy_o(busy_w[s]),
      .wake_o(wake_o[s]),
      .hdr_o(hdr_w[s]),
      .pay_o(pay_w[s]),
      .dlv_o(dlv_w[s])
    );
  end

  mbx_irq #(.W(ST_W)) u_irq (
    .clk(clk), .rst(rst),
    .set_i(set_w),
    .en_wr(reg_wr && (reg_addr == A_IEN)),
    .clr_wr(reg_wr && (reg_addr == A_ICLR)),
    .wdata_i(reg_wdata[ST_W-1:0]),
    .en_o(ien_w),
    .stat_o(ist_w),
    .irq_o(irq_o)
  );

  for (genvar i = 0; i < NUM_ID; i++) begin : g_idwr
    assign id_wr[i] = reg_wr && (reg_addr == A_ID0 + ADDR_W'(4 * i));
  end

  mbx_ids #(.NUM_ID(NUM_ID)) u_ids (
    .clk(clk), .rst(rst),
    .wr_i(id_wr),
    .wdata_i(reg_wdata),
    .ids_o(ids_w),
    .ok_o(ids_ok_o)
  );

  logic [31:0]       rd_mux;
  logic [ADDR_W-1:0] win_off, win_rem, win_slot, win_word;

  always_comb begin
    rd_mux   = '0;
    win_off  = reg_addr - A_RXWIN;
    win_rem  = win_off % ADDR_W'(PSTRIDE);
    win_slot = win_rem / ADDR_W'(SLOT_STRIDE);
    win_word = (win_rem % ADDR_W'(SLOT_STRIDE)) >> 2;
    if (reg_addr == A_TX_HDR) rd_mux = tx_hdr_q;
    if (reg_addr == A_TX_LO)  rd_mux = tx_lo_q;
    if (reg_addr == A_TX_HI)  rd_mux = tx_hi_q;
    if (reg_addr == A_STAT)   rd_mux = 32'(stat_w);
    if (reg_addr == A_IEN)    rd_mux = 32'(ien_w);
    if (reg_addr == A_ISTAT)  rd_mux = 32'(ist_w);
    for (int s = 0; s < NUM_SLOT; s++) begin
      if (reg_addr == A_CTL0 + ADDR_W'(4 * s))
        rd_mux = 32'({busy_w[s]} << CTL_SEND) | 32'({wake_o[s]} << CTL_WAKE);
      if (reg_addr >= A_RXWIN && reg_addr < RXWIN_END && win_slot == ADDR_W'(s)) begin
        case (win_word)
          12'd0:   rd_mux = hdr_w[s];
          12'd1:   rd_mux = pay_w[s][31:0];
          12'd2:   rd_mux = pay_w[s][63:32];
          default: rd_mux = '0;
        endcase
      end
    end
    for (int i = 0; i < NUM_ID; i++)
      if (reg_addr == A_ID0 + ADDR_W'(4 * i)) rd_mux = ids_w[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
    else             reg_rdata <= '0;
  end

  // R2: a status bit only rises after a slot control write
  p_status_rise_needs_send_r2: assert property (@(posedge clk) disable iff (rst)
    (|(stat_w & ~$past(stat_w))) |-> $past(|ctl_wr));

  // R9: an enabled latched status bit drives the interrupt line
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (rst)
    (|(ist_w & ien_w) && !reg_wr) |=> irq_o);
endmodule

// File: tb/tb_mbx_ctrl.sv
module tb_mbx_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, ids_ok_o;
  logic [3:0]  wake_o;

  int n_chk = 0, n_err = 0;

  mbx_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .wake_o(wake_o), .ids_ok_o(ids_ok_o)
  );

  always #5 clk = ~clk;

  logic [31:0] m_pend, m_ist, m_en, tx_h, tx_l, tx_u;
  logic [3:0]  m_busy, m_wake;
  logic [31:0] m_hdr [4];
  logic [31:0] m_lo  [4];
  logic [31:0] m_hi  [4];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_tx(logic [31:0] h, logic [31:0] l, logic [31:0] u);
    wr(12'h000, h); wr(12'h004, l); wr(12'h008, u);
    tx_h = h; tx_l = l; tx_u = u;
  endtask

  task automatic do_ctl(int s, logic [31:0] d);
    wr(12'h00C + 12'(4 * s), d);
    m_wake[s] = d[16];
    if (d[8]) begin
      for (int p = 0; p < 8; p++) m_pend[p*4 + s] = 1'b0;
      m_busy[s] = 1'b0;
    end else if (d[0] && !m_busy[s]) begin
      m_hdr[s] = tx_h; m_lo[s] = tx_l; m_hi[s] = tx_u;
      for (int p = 0; p < 8; p++) begin
        m_pend[p*4 + s] = tx_h[16 + p];
        if (tx_h[16 + p]) m_ist[p*4 + s] = 1'b1;
      end
      m_busy[s] = |tx_h[23:16];
    end
  endtask

  task automatic do_ack(logic [31:0] d);
    wr(12'h024, d);
    m_pend = m_pend & ~d;
    for (int s = 0; s < 4; s++) begin
      logic any;
      any = 1'b0;
      for (int p = 0; p < 8; p++) any = any | m_pend[p*4 + s];
      if (!any) m_busy[s] = 1'b0;
    end
  endtask

  task automatic do_clr(logic [31:0] d);
    wr(12'h3F4, d);
    m_ist = m_ist & ~d;
  endtask

  task automatic do_en(logic [31:0] d);
    wr(12'h3F0, d);
    m_en = d;
  endtask

  function automatic logic [31:0] exp_ctl(int s);
    return {15'b0, m_wake[s], 15'b0, m_busy[s]};
  endfunction

  task automatic chk_slot(string tag, int s);
    logic [31:0] v;
    rd(12'h00C + 12'(4 * s), v);
    chk(tag, v, exp_ctl(s));
  endtask

  task automatic chk_win(string tag, int p, int s);
    logic [31:0] v;
    logic [11:0] b;
    b = 12'h02C + 12'(p * 48 + s * 12);
    rd(b, v);        chk({tag, " hdr"}, v, m_hdr[s]);
    rd(b + 12'd4, v); chk({tag, " lo"}, v, m_lo[s]);
    rd(b + 12'd8, v); chk({tag, " hi"}, v, m_hi[s]);
  endtask

  initial begin
    #2000000;
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    m_pend = '0; m_ist = '0; m_en = '0; tx_h = '0; tx_l = '0; tx_u = '0;
    m_busy = '0; m_wake = '0;
    for (int s = 0; s < 4; s++) begin m_hdr[s] = '0; m_lo[s] = '0; m_hi[s] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(12'h01C, v); chk("R1 status", v, 32'h0);
    rd(12'h00C, v); chk("R1 ctl0", v, 32'h0);
    rd(12'h3F8, v); chk("R1 irq status", v, 32'h0);
    chk("R1 outputs", {28'b0, wake_o}, 32'h0);
    chk("R1 irq/ok", {30'b0, irq_o, ids_ok_o}, 32'h0);

    // R2 send to receivers 0 and 2 on slot 3
    set_tx(32'h0305_0012, 32'hCAFE_0001, 32'h1234_5678);
    do_ctl(3, 32'h1);
    rd(12'h01C, v); chk("R2 status", v, 32'h0000_0808);
    chk_slot("R2 busy", 3);

    // R3 receiver window and shadow isolation
    chk_win("R3 rx2 slot3", 2, 3);
    set_tx(32'h0000_0000, 32'h1111_1111, 32'h2222_2222);
    chk_win("R3 shadow kept", 0, 3);

    // R6 send while busy
    set_tx(32'h03FF_0000, 32'h9999_9999, 32'h8888_8888);
    do_ctl(3, 32'h1);
    rd(12'h01C, v); chk("R6 status unchanged", v, 32'h0000_0808);
    chk_win("R6 msg unchanged", 2, 3);

    // R4 partial acknowledge, R5 final acknowledge
    do_ack(32'h0000_0008);
    rd(12'h01C, v); chk("R4 status", v, 32'h0000_0800);
    chk_slot("R4 still busy", 3);
    do_ack(32'h0000_0800);
    rd(12'h01C, v); chk("R5 status", v, 32'h0);
    chk_slot("R5 done", 3);

    // R7 cancel, and cancel together with send
    set_tx(32'h01FF_0000, 32'h5, 32'h6);
    do_ctl(1, 32'h1);
    do_ctl(1, 32'h100);
    rd(12'h01C, v); chk("R7 status", v, 32'h0);
    chk_slot("R7 ctl", 1);
    do_ctl(1, 32'h101);
    rd(12'h01C, v); chk("R7 cancel+send", v, 32'h0);

    // R2 empty destination bitmap
    set_tx(32'h0200_0000, 32'h1, 32'h2);
    do_ctl(2, 32'h1);
    chk_slot("R2 zero dest", 2);

    // R8 wake
    do_ctl(0, 32'h0001_0000);
    chk_slot("R8 ctl", 0);
    chk("R8 wake_o", {28'b0, wake_o}, 32'h1);
    do_ctl(0, 32'h0);

    // R9 interrupt latch, enable, clear
    do_clr(32'hFFFF_FFFF);
    do_en(32'h0);
    set_tx(32'h0002_0000, 32'h0, 32'h0);
    do_ctl(0, 32'h1);
    rd(12'h3F8, v); chk("R9 latched", v, m_ist);
    chk("R9 masked", {31'b0, irq_o}, 32'h0);
    do_en(32'h0000_0010);
    rd(12'h3F0, v); chk("R9 enable rb", v, 32'h10);
    chk("R9 raised", {31'b0, irq_o}, 32'h1);
    do_clr(32'h0000_0010);
    rd(12'h3F8, v); chk("R9 cleared", v, 32'h0);
    chk("R9 dropped", {31'b0, irq_o}, 32'h0);
    rd(12'h01C, v); chk("R9 pend kept", v, 32'h10);
    do_ack(32'h10);

    // R10 identifiers
    for (int i = 0; i < 5; i++) wr(12'h200 + 12'(4 * i), 32'h8182_8384 + 32'(i));
    rd(12'h204, v); chk("R10 readback", v, 32'h8182_8385);
    chk("R10 ok", {31'b0, ids_ok_o}, 32'h1);
    wr(12'h208, 32'h8100_8384);
    rd(12'h208, v);
    chk("R10 zero byte", {31'b0, ids_ok_o}, 32'h0);

    // R11 unmapped read
    rd(12'h300, v); chk("R11 unmapped", v, 32'h0);

    // random rounds
    for (int it = 0; it < 300; it++) begin
      int op, s;
      op = int'($urandom_range(0, 5));
      s  = int'($urandom_range(0, 3));
      if (op <= 1) begin
        set_tx({8'(s), 8'($urandom), 16'($urandom)}, $urandom, $urandom);
        do_ctl(s, ($urandom_range(0, 7) == 0) ? 32'h100 : 32'h1);
      end else if (op <= 3) begin
        do_ack($urandom & $urandom);
      end else if (op == 4) begin
        do_clr($urandom);
      end else begin
        do_en($urandom);
      end
      rd(12'h01C, v); chk("R4 R5 random status", v, m_pend);
      chk("R9 random irq", {31'b0, irq_o}, {31'b0, |(m_ist & m_en)});
      chk_slot("R5 random ctl", s);
      if (it % 10 == 0) begin
        rd(12'h3F8, v); chk("R9 random latch", v, m_ist);
        chk_win("R3 random window", int'($urandom_range(0, 7)), s);
      end
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule